// File: doc/BRIEF.md
# Floating-Point Result Condition Flag Generator

This block sits at the tail of a floating-point datapath. It receives the final 80-bit extended-precision result of an operation and derives four condition flags from that value alone: negative, zero, infinity and not-a-number. The kind of operation that produced the result plays no part in the flags, so every instruction that touches them sets them by one and the same rule.

An update strobe, `upd_i`, selects between two outcomes. When it is sampled high on a clock edge, the flags are rewritten from the current result. When it is low, the registered flags keep their value. The flags are presented as a 4-bit condition field that later conditional-test logic can decode. Reset clears all four flags.

The 80-bit input is laid out as a sign in bit 79, a 15-bit biased exponent in bits 78:64, and a 64-bit significand in bits 63:0. Bit 63 of the significand is an explicit integer bit, and bits 62:0 form the fraction.

Top module: `fcc_gen`

## Requirements
- R1: The flag field is `cc_o[3]`=negative, `cc_o[2]`=zero, `cc_o[1]`=infinity, `cc_o[0]`=not-a-number. It changes on the clock edge that samples `upd_i` high and is visible in the cycle after that edge.
- R2: On every update, the negative flag equals the sign bit `res_i[79]`, whatever the class of the value (zero, infinity and NaN included).
- R3: When `upd_i` is low on a clock edge, `cc_o` keeps its previous value, whatever `res_i` carries.
- R4: A positive normalized finite result (exponent neither 0 nor all ones, integer bit set, sign 0) gives `cc_o`=4'b0000.
- R5: A result with exponent 0 and significand 0 sets the zero flag, so +0 gives 4'b0100 and -0 gives 4'b1100.
- R6: A result with exponent all ones and fraction bits 62:0 all zero sets the infinity flag, whatever the integer bit 63 holds. -inf gives 4'b1010 and +inf gives 4'b0010.
- R7: A result with exponent all ones and a nonzero fraction (bits 62:0) sets the not-a-number flag, so +NaN gives 4'b0001 and -NaN gives 4'b1001.
- R8: Denormal values (exponent 0, significand nonzero) and unnormal values (exponent neither 0 nor all ones, integer bit clear) leave the zero, infinity and not-a-number flags clear, and set only the negative flag from the sign.
- R9: At most one of the zero, infinity and not-a-number flags is set at any time.
- R10: A synchronous active-high reset `rst` clears `cc_o` to 4'b0000 on the next edge. Reset takes priority over `upd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Rewrite the flags from `res_i` on this edge |
| res_i | input | 80 | Extended-precision result: sign, exponent, significand |
| cc_o | output | 4 | Registered flags {negative, zero, infinity, NaN} |

## Verification
The embedded properties are checked on every cycle. They cover the following: the flags hold while the strobe is low; the negative flag follows the sampled sign; the three class flags are mutually exclusive; any all-ones-exponent value with a nonzero fraction raises the NaN flag; and reset clears the field. The exact flag patterns for each value class can only be shown by the bench's scenarios. These include the boundary cases: signed zeros, infinity with and without the integer bit, denormal and unnormal encodings, an idle strobe over a changed input, and reset arriving together with an update.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int EXP_W  = 15;
    localparam int MAN_W  = 64;
    localparam int FMT_W  = 1 + EXP_W + MAN_W;
    localparam int FRAC_W = MAN_W - 1;
    localparam int CC_W   = 4;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] sig;
    } ext_val_t;

    typedef enum logic [1:0] {
        VC_FINITE = 2'd0,
        VC_ZERO   = 2'd1,
        VC_INF    = 2'd2,
        VC_NAN    = 2'd3
    } val_class_t;

    // Bit order is what downstream test decoding relies on: N,Z,I,NaN.
    typedef struct packed {
        logic neg;
        logic zer;
        logic inf;
        logic nan;
    } cc_t;

    function automatic cc_t class_to_cc(val_class_t cls, logic sgn);
        cc_t r;
        r.neg = sgn;
        r.zer = (cls == VC_ZERO);
        r.inf = (cls == VC_INF);
        r.nan = (cls == VC_NAN);
        return r;
    endfunction

endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
    import fcc_pkg::*;
(
    input  ext_val_t   val_i,
    output val_class_t cls_o
);
    logic exp_max;
    logic exp_min;
    logic frac_nz;
    logic sig_nz;

    always_comb begin
        exp_max = &val_i.expo;
        exp_min = ~|val_i.expo;
        frac_nz = |val_i.sig[FRAC_W-1:0];
        sig_nz  = |val_i.sig;
    end

    always_comb begin
        if (exp_max) begin
            cls_o = frac_nz ? VC_NAN : VC_INF;
        end else if (exp_min && !sig_nz) begin
            cls_o = VC_ZERO;
        end else begin
            cls_o = VC_FINITE;
        end
    end
endmodule

// File: rtl/fcc_flag_reg.sv
module fcc_flag_reg
    import fcc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  cc_t  cc_d,
    output cc_t  cc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= '0;
        end else if (load_i) begin
            cc_q <= cc_d;
        end
    end

    // R3: flags hold when no update is requested
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cc_q));

    // R1: an update lands in the cycle after the strobe
    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cc_q == $past(cc_d)));
endmodule

// File: rtl/fcc_gen.sv
module fcc_gen
    import fcc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd_i,
    input  logic [FMT_W-1:0]      res_i,
    output logic [CC_W-1:0]       cc_o
);
    ext_val_t   val;
    val_class_t cls;
    cc_t        cc_next;
    cc_t        cc_reg;

    assign val = ext_val_t'(res_i);

    fcc_classify u_cls (
        .val_i (val),
        .cls_o (cls)
    );

    assign cc_next = class_to_cc(cls, val.sign);

    fcc_flag_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .load_i (upd_i),
        .cc_d   (cc_next),
        .cc_q   (cc_reg)
    );

    assign cc_o = cc_reg;

    // R2: negative flag tracks the sampled sign bit
    p_sign_r2: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (cc_o[3] == $past(res_i[FMT_W-1])));

    // R9: class flags never overlap
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cc_o[2:0]));

    // R7: all-ones exponent with a nonzero fraction always flags NaN
    p_nan_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_i && (&res_i[FMT_W-2:MAN_W]) && (|res_i[FRAC_W-1:0])) |=> cc_o[0]);

    // R10: reset clears every flag
    p_clear_r10: assert property (@(posedge clk)
        rst |=> (cc_o == '0));
endmodule

// File: tb/sim_fcc_gen.sv
module sim_fcc_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_i = 1'b0;
    logic [79:0] res_i = '0;
    logic [3:0]  cc_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] model = 4'b0000;

    always #5 clk = ~clk;

    fcc_gen u0 (
        .clk   (clk),
        .rst   (rst),
        .upd_i (upd_i),
        .res_i (res_i),
        .cc_o  (cc_o)
    );

    function automatic logic [79:0] mk(logic s, logic [14:0] e, logic [63:0] m);
        return {s, e, m};
    endfunction

    // Reference flags from the requirements: {N, Z, I, NaN}
    function automatic logic [3:0] ref_cc(logic [79:0] v);
        logic        s = v[79];
        logic [14:0] e = v[78:64];
        logic [63:0] m = v[63:0];
        if (e == 15'h7FFF)
            return (m[62:0] != 0) ? {s, 3'b001} : {s, 3'b010};
        if (e == 15'h0000 && m == 64'd0)
            return {s, 3'b100};
        return {s, 3'b000};
    endfunction

    task automatic drive(input logic r, input logic u, input logic [79:0] v, input string tag);
        @(negedge clk);
        rst   = r;
        upd_i = u;
        res_i = v;
        if (r) model = 4'b0000;
        else if (u) model = ref_cc(v);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each registered result after the edge settles
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (cc_o !== e) begin
                fails++;
                $display("FAIL %s: cc_o=%b expected=%b", t, cc_o, e);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        drive(1, 0, '0, "R10 reset state");
        drive(1, 1, mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), "R10 reset over update");
        drive(0, 1, mk(0, 15'h3FFF, 64'h8000_0000_0000_0000), "R4 positive normal");
        drive(0, 1, mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), "R6 minus infinity");
        drive(0, 0, mk(0, 15'h0000, 64'h0), "R3 hold with zero input");
        drive(0, 0, mk(0, 15'h7FFF, 64'h1), "R3 hold with NaN input");
        drive(0, 1, mk(0, 15'h0000, 64'h0), "R5 plus zero");
        drive(0, 1, mk(1, 15'h0000, 64'h0), "R5 R2 minus zero");
        drive(0, 1, mk(0, 15'h7FFF, 64'h0), "R6 infinity without integer bit");
        drive(0, 1, mk(0, 15'h7FFF, 64'hC000_0000_0000_0000), "R7 plus NaN");
        drive(0, 1, mk(1, 15'h7FFF, 64'h0000_0000_0000_0001), "R7 R2 minus NaN low bit");
        drive(0, 1, mk(0, 15'h0000, 64'h0000_0000_0000_0001), "R8 plus denormal");
        drive(0, 1, mk(1, 15'h0000, 64'h4000_0000_0000_0000), "R8 minus denormal");
        drive(0, 1, mk(1, 15'h1234, 64'h0000_0000_0000_0005), "R8 minus unnormal");
        drive(0, 1, mk(1, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF), "R2 R1 minus largest normal");
        drive(0, 1, mk(0, 15'h0001, 64'h8000_0000_0000_0000), "R4 smallest normal");
        drive(0, 1, mk(1, 15'h7FFF, 64'h8000_0000_0000_0000), "R1 R9 minus infinity again");
        drive(1, 1, mk(0, 15'h7FFF, 64'h1), "R10 mid-run reset");
        drive(0, 0, mk(1, 15'h7FFF, 64'h0), "R3 hold after reset");
        drive(0, 1, mk(0, 15'h0000, 64'h0), "R9 zero after reset");
        drive(0, 0, '0, "R3 final idle");
        @(posedge clk);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule